// File: doc/BRIEF.md
# Dual-Clock FIFO with Combined Status Flags

This block is a first-in first-out buffer whose write side and read side each run on their own free-running clock. The two clocks may come from one source or be fully unrelated, and both sides may move data at the same time. Its default organisation is 4096 words of 9 bits. An optional parity mode turns the top data bit into an even-parity bit. The writer generates that bit, and the reader checks it. A single active-high master reset empties the buffer and clears every flag.

The data interfaces use valid/ready handshakes. On the write side, `wr_ready` is low while the buffer is full. A word offered with `wr_valid` while `wr_ready` is low is dropped and raises the error flag. On the read side, `rd_ready` is the consumer's request. A request while the buffer is empty is refused, and it also raises the error flag. A granted request produces a one-cycle `rd_valid` pulse with the word on `rd_data`. The data output floats when the output enable is low.

Occupancy is reported on few pins, so some flags are shared. One flag covers both the empty and the full case. Another covers both the quarter-full and the three-quarter-full case. The half-full flag tells the two cases of each shared flag apart. Pointers cross between the clock domains in Gray code through two-stage synchronisers. As a result, a flag may trail the other side's activity by a few cycles of the other clock.

Top module: `dcfifo_flags`

## Requirements
- R1: With `wr_valid` high and `wr_ready` high at a rising `wclk` edge, `wr_data` is stored. `wr_ready` is high exactly when the buffer is not full.
- R2: With `rd_ready` high and the buffer not empty at a rising `rclk` edge, the oldest word appears on `rd_data` and `rd_valid` is high for that one cycle. Words leave in the order they were written.
- R3: A write offered while the buffer is full is ignored. The stored contents and the occupancy do not change, and the buffer never holds more than its depth.
- R4: A read requested while the buffer is empty is ignored. `rd_valid` stays low, and `rd_data` keeps the last word read.
- R5: A write offered while full, or a read requested while empty, sets `flag_err`. The flag stays set until master reset.
- R6: With `parity_en` high, the writer replaces bit DW-1 of each stored word with the XOR of bits DW-2..0, so every stored word has even parity. With `parity_en` low, words pass through unchanged.
- R7: With `parity_en` high, a word read whose bits XOR to 1 sets the sticky `flag_err`.
- R8: `flag_ef` is high when the occupancy is 0 or equal to the depth.
- R9: `flag_qtr` is high when the occupancy is at most a quarter of the depth, or at least three quarters of it.
- R10: `flag_half` is high when the occupancy is above half the depth.
- R11: With `oe` low, `rd_data` is high-impedance. With `oe` high, it shows the held output word.
- R12: Master reset `mr` leaves the buffer empty, with `flag_ef` high, `flag_qtr` high, `flag_half` low, `flag_err` low and `rd_valid` low.
- R13: Writes and reads running at the same time on unrelated clocks lose, repeat and reorder no word. The Gray pointer moves at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mr | input | 1 | Master reset, active high, asynchronous |
| parity_en | input | 1 | Parity generation and checking on |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Buffer can take a word |
| wr_data | input | DW | Write data |
| rd_ready | input | 1 | Read request |
| rd_valid | output | 1 | Word presented this cycle |
| oe | input | 1 | Output enable for rd_data |
| rd_data | output | DW | Read data, high-impedance when oe is low |
| flag_ef | output | 1 | Empty or full |
| flag_qtr | output | 1 | Quarter-full or less, or three-quarter-full or more |
| flag_half | output | 1 | More than half full |
| flag_err | output | 1 | Sticky error |

## Verification
The assertions check a few properties on every clock edge:
- occupancy never goes past the depth;
- both error registers stay set once set;
- every word stored in parity mode has even parity;
- a refused read leaves the output word and `rd_valid` untouched;
- the write Gray pointer changes one bit at a time.

Only the bench's scenarios can show the rest:
- the level flags at every occupancy from empty to full and back;
- the data order across two unrelated clocks;
- that a dropped write leaves no extra word behind;
- the parity error on a bad word;
- the high-impedance output.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef struct packed {
    logic full;
    logic qtr;
    logic half;
  } lvl_flags_t;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 13
) (
  input  logic         dclk,
  input  logic         mr,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  logic [W-1:0] stage1;

  always_ff @(posedge dclk or posedge mr) begin
    if (mr) begin
      stage1 <= '0;
      dst    <= '0;
    end else begin
      stage1 <= src;
      dst    <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          mr,
  input  logic          parity_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rgray_s,
  output logic          wr_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW:0]   wgray,
  output lvl_flags_t    lvl,
  output logic          err_ovf
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW:0] QTR_C   = (AW+1)'(DEPTH / 4);
  localparam logic [AW:0] HALF_C  = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] TQTR_C  = (AW+1)'((3 * DEPTH) / 4);

  logic [AW:0] wbin, wbin_nxt, rbin_s, count;
  logic        full, fire;

  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign full      = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign wr_ready  = ~full;
  assign fire      = wr_valid & ~full;
  assign wbin_nxt  = wbin + 1'b1;
  assign count     = wbin - rbin_s;
  assign mem_we    = fire;
  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = parity_en ? {^wr_data[DW-2:0], wr_data[DW-2:0]} : wr_data;

  assign lvl.full = full;
  assign lvl.qtr  = (count <= QTR_C) || (count >= TQTR_C);
  assign lvl.half = (count > HALF_C);

  always_ff @(posedge wclk or posedge mr) begin
    if (mr) begin
      wbin    <= '0;
      wgray   <= '0;
      err_ovf <= 1'b0;
    end else begin
      if (fire) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (wr_valid && full) err_ovf <= 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (mr)
    count <= DEPTH_C);
  p_err_sticky_r5: assert property (@(posedge wclk) disable iff (mr)
    err_ovf |=> err_ovf);
  p_even_store_r6: assert property (@(posedge wclk) disable iff (mr)
    (mem_we && parity_en) |-> (^mem_wdata == 1'b0));
  p_gray_step_r13: assert property (@(posedge wclk) disable iff (mr)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          mr,
  input  logic          parity_en,
  input  logic          rd_ready,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] q,
  output logic          rd_valid,
  output logic          empty,
  output logic          err_rd
);
  logic [AW:0] rbin, rbin_nxt;
  logic        fire;

  assign empty     = (rgray == wgray_s);
  assign fire      = rd_ready & ~empty;
  assign rbin_nxt  = rbin + 1'b1;
  assign mem_raddr = rbin[AW-1:0];

  always_ff @(posedge rclk or posedge mr) begin
    if (mr) begin
      rbin     <= '0;
      rgray    <= '0;
      q        <= '0;
      rd_valid <= 1'b0;
      err_rd   <= 1'b0;
    end else begin
      rd_valid <= fire;
      if (fire) begin
        q     <= mem_rdata;
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
      if ((rd_ready && empty) || (fire && parity_en && (^mem_rdata)))
        err_rd <= 1'b1;
    end
  end

  p_hold_on_empty_r4: assert property (@(posedge rclk) disable iff (mr)
    (rd_ready && empty) |=> ($stable(q) && !rd_valid));
  p_err_sticky_r7: assert property (@(posedge rclk) disable iff (mr)
    err_rd |=> err_rd);
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcf_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mr,
  input  logic          parity_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  input  logic          oe,
  output logic [DW-1:0] rd_data,
  output logic          flag_ef,
  output logic          flag_qtr,
  output logic          flag_half,
  output logic          flag_err
);
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic          mem_we, empty, err_ovf, err_rd;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata, q;
  lvl_flags_t    lvl;

  dcf_wr_ctrl #(.AW(AW), .DW(DW)) u_wr (
    .wclk(wclk), .mr(mr), .parity_en(parity_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .rgray_s(rgray_s), .wr_ready(wr_ready),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wgray(wgray), .lvl(lvl), .err_ovf(err_ovf)
  );

  dcf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  dcf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .mr(mr), .parity_en(parity_en), .rd_ready(rd_ready),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .rgray(rgray), .q(q), .rd_valid(rd_valid), .empty(empty), .err_rd(err_rd)
  );

  dcf_sync #(.W(AW+1)) u_w2r (.dclk(rclk), .mr(mr), .src(wgray), .dst(wgray_s));
  dcf_sync #(.W(AW+1)) u_r2w (.dclk(wclk), .mr(mr), .src(rgray), .dst(rgray_s));

  assign rd_data   = oe ? q : {DW{1'bz}};
  assign flag_ef   = lvl.full | empty;
  assign flag_qtr  = lvl.qtr;
  assign flag_half = lvl.half;
  assign flag_err  = err_ovf | err_rd;
endmodule

// File: tb/dcfifo_flags_bench.sv
module dcfifo_flags_bench;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, mr = 1'b1, parity_en = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, oe = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, flag_ef, flag_qtr, flag_half, flag_err;
  wire  [DW-1:0] rd_data;
  int checks = 0, fails = 0;

  dcfifo_flags #(.AW(AW), .DW(DW)) u_dcfifo_flags (
    .wclk(wclk), .rclk(rclk), .mr(mr), .parity_en(parity_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .oe(oe), .rd_data(rd_data),
    .flag_ef(flag_ef), .flag_qtr(flag_qtr), .flag_half(flag_half),
    .flag_err(flag_err)
  );

  initial begin #1; forever #4 wclk = ~wclk; end
  always #7 rclk = ~rclk;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 5) & 255);
  endfunction
  function automatic logic [DW-1:0] pword(int k);
    return {^pat(k), pat(k)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset();
    wr_valid = 1'b0; rd_ready = 1'b0; mr = 1'b1;
    repeat (3) @(negedge wclk);
    mr = 1'b0;
    settle();
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge wclk); wr_valid = 1'b1; wr_data = v;
    @(negedge wclk); wr_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk); rd_ready = 1'b1;
    @(negedge rclk); rd_ready = 1'b0;
  endtask

  task automatic level(input int n);
    check("R8 empty/full flag", 32'(flag_ef), 32'(n == 0 || n == DEPTH));
    check("R9 quarter flag", 32'(flag_qtr), 32'(n <= DEPTH/4 || n >= 3*DEPTH/4));
    check("R10 half flag", 32'(flag_half), 32'(n > DEPTH/2));
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    level(0);
    check("R12 err after reset", 32'(flag_err), 0);
    check("R12 rd_valid after reset", 32'(rd_valid), 0);
    check("R1 ready after reset", 32'(wr_ready), 1);

    // fill sweep with parity generation, bit 8 deliberately wrong on input
    parity_en = 1'b1;
    for (int n = 1; n <= DEPTH; n++) begin
      push({~(^pat(n)), pat(n)});
      settle();
      level(n);
      check("R1 wr_ready vs full", 32'(wr_ready), 32'(n < DEPTH));
    end

    // write while full: dropped, sticky error
    push(9'h1AA);
    settle();
    check("R5 error on overflow", 32'(flag_err), 1);
    level(DEPTH);

    // drain sweep: order, parity-generated bit, no extra word
    for (int n = 1; n <= DEPTH; n++) begin
      pop();
      check("R2 rd_valid", 32'(rd_valid), 1);
      check("R2 R6 data order", 32'(rd_data), 32'(pword(n)));
      settle();
      level(DEPTH - n);
    end
    check("R3 no extra word after dropped write", 32'(flag_ef & ~flag_half), 1);

    // read while empty: output held
    pop();
    check("R4 no rd_valid on empty", 32'(rd_valid), 0);
    check("R4 output held", 32'(rd_data), 32'(pword(DEPTH)));
    check("R5 error stays set", 32'(flag_err), 1);
    do_reset();
    check("R12 reset clears err", 32'(flag_err), 0);
    pop();
    check("R5 error on underflow", 32'(flag_err), 1);
    do_reset();

    // output enable
    oe = 1'b0; #1;
    check("R11 high impedance", 32'(rd_data === {DW{1'bz}}), 1);
    oe = 1'b1; #1;
    check("R11 driven", 32'(rd_data), 0);

    // parity off: pass-through, no error
    parity_en = 1'b0;
    push(9'h001);
    settle();
    pop();
    check("R6 pass-through", 32'(rd_data), 32'h001);
    check("R6 no error with parity off", 32'(flag_err), 0);
    // bad parity word read with checking on
    push(9'h001);
    settle();
    parity_en = 1'b1;
    pop();
    check("R7 data", 32'(rd_data), 32'h001);
    check("R7 parity error", 32'(flag_err), 1);
    do_reset();

    // concurrent streaming on unrelated clocks
    fork
      begin
        int i = 0;
        while (i < 40) begin
          @(negedge wclk);
          if (wr_ready) begin
            wr_valid = 1'b1; wr_data = {1'b0, pat(100 + i)}; i++;
          end else wr_valid = 1'b0;
        end
        @(negedge wclk); wr_valid = 1'b0;
      end
      begin
        int got = 0;
        while (got < 40) begin
          @(negedge rclk);
          if (rd_valid) begin
            check("R13 stream order", 32'(rd_data), 32'(pword(100 + got)));
            got++;
          end
          rd_ready = (got < 40) && !(flag_ef && !flag_half);
        end
        rd_ready = 1'b0;
      end
    join
    settle();
    check("R13 no error during stream", 32'(flag_err), 0);
    level(0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule